// File: doc/BRIEF.md
# Interleaved Parity Read Checker

This block sits on the read path of a ternary match array whose entries are 72 bits wide. The two top bits of each entry hold parity written by software, and the low 70 bits hold data. Each returned entry arrives as one beat on a valid/ready stream. When checking is enabled for that beat, the block tests two even-parity groups. One group is the even-indexed data bits together with bit 70. The other group is the odd-indexed data bits together with bit 71.

The entry passes through one register stage without change. An error flag travels with the entry and is valid whenever the output valid is high. The block does not correct data and does not compute parity on writes, so whoever writes an entry must supply correct parity.

Back-pressure rules:
- A beat is accepted when `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output slot is empty or is being drained in that cycle.
- While `out_valid` is high and `out_ready` is low, the output word and its flag are held.

Top module: `parity_read_checker`

## Requirements
- R1: After reset, `out_valid` and `out_err` are 0 and `in_ready` is 1.
- R2: A beat accepted on a rising edge appears on `out_data` after that edge, with `out_valid` high and every bit unchanged.
- R3: Bit 70 is the even-parity bit of data bits 0, 2, ..., 68. With checking enabled, an odd count of ones among those bits plus bit 70 raises `out_err`.
- R4: Bit 71 is the even-parity bit of data bits 1, 3, ..., 69. With checking enabled, an odd count of ones among those bits plus bit 71 raises `out_err`.
- R5: `out_err` is the OR of the two group failures. Two flips inside one group raise no error, while one flip in each group raises an error.
- R6: When `chk_en` is 0 for a beat, `out_err` is 0 for that beat and the data is still delivered.
- R7: A beat flagged with an error is still delivered with its data unmodified.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output holds `out_data` and `out_err` and drives `in_ready` low.
- R9: `out_err` is 0 whenever `out_valid` is 0.
- R10: `chk_en` is sampled together with the beat. Changing it while the beat waits at the output does not alter that beat's `out_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en | input | 1 | Enables the parity check for the accepted beat |
| in_valid | input | 1 | Read entry valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 72 | Read entry, parity in bits 71:70 |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 72 | Entry as read |
| out_err | output | 1 | Parity failure for this entry |

## Verification
The bench first sends good-parity entries with random payloads, each with checking enabled and disabled; this separates a correct checker from one that flags clean data. Every one of the 72 single-bit flips is then sent, which shows that each data bit is mapped to the right group and that both parity bits are observed. All pairs of flipped bits follow: pairs within one group must cancel and pairs across groups must fire, which tells an OR of group results apart from a single XOR over the whole entry. A stalled output with a late change of the enable covers holding under back-pressure and sampling the enable with the beat.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned ENTRY_W = 72;
  localparam int unsigned GROUPS  = 2;
  typedef enum logic [0:0] {GRP_EVEN = 1'b0, GRP_ODD = 1'b1} grp_e;
endpackage

// File: rtl/interleave_xor.sv
module interleave_xor #(
  parameter int unsigned ENTRY_W = 72,
  parameter int unsigned PHASE   = 0
) (
  input  logic [ENTRY_W-1:0] word,
  output logic               par
);
  localparam int unsigned PAY_W = ENTRY_W - 2;
  localparam int unsigned N     = (PAY_W - PHASE + 1) / 2;

  logic [N-1:0] picked;
  for (genvar g = 0; g < N; g++) begin : g_pick
    assign picked[g] = word[2*g + PHASE];
  end
  assign par = ^picked;
endmodule

// File: rtl/parity_verdict.sv
module parity_verdict #(
  parameter int unsigned ENTRY_W = 72
) (
  input  logic [ENTRY_W-1:0] word,
  input  logic               chk_en,
  output logic               err
);
  localparam int unsigned PAY_W = ENTRY_W - 2;

  logic [ipc_pkg::GROUPS-1:0] grp_par;
  logic [ipc_pkg::GROUPS-1:0] grp_fail;

  for (genvar g = 0; g < ipc_pkg::GROUPS; g++) begin : g_grp
    interleave_xor #(.ENTRY_W(ENTRY_W), .PHASE(g)) u_x (
      .word (word),
      .par  (grp_par[g])
    );
    assign grp_fail[g] = grp_par[g] ^ word[PAY_W + g];
  end

  assign err = chk_en & (|grp_fail);
endmodule

// File: rtl/beat_register.sv
module beat_register #(
  parameter int unsigned ENTRY_W = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_data,
  input  logic               in_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ENTRY_W-1:0] out_data,
  output logic               out_err
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_err   <= in_err;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err))); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data))); // R2
endmodule

// File: rtl/parity_read_checker.sv
module parity_read_checker #(
  parameter int unsigned ENTRY_W = ipc_pkg::ENTRY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ENTRY_W-1:0] out_data,
  output logic               out_err
);
  logic verdict;

  parity_verdict #(.ENTRY_W(ENTRY_W)) u_verdict (
    .word   (in_data),
    .chk_en (chk_en),
    .err    (verdict)
  );

  beat_register #(.ENTRY_W(ENTRY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_err    (verdict),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_err   (out_err)
  );

  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_err); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !chk_en) |=> !out_err); // R6
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
endmodule

// File: tb/test_parity_read_checker.sv
module test_parity_read_checker;
  localparam int W = 72;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_err;
  logic [W-1:0] out_data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  parity_read_checker i_parity_read_checker (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_err(out_err));

  function automatic logic [W-1:0] good(input logic [W-1:0] d);
    logic pe = 1'b0, po = 1'b0;
    for (int i = 0; i < W - 2; i++) begin
      if (i % 2 == 0) pe ^= d[i]; else po ^= d[i];
    end
    d[70] = pe; d[71] = po;
    return d;
  endfunction

  function automatic logic exp_err(input logic [W-1:0] d, input logic en);
    logic pe = d[70], po = d[71];
    for (int i = 0; i < W - 2; i++) begin
      if (i % 2 == 0) pe ^= d[i]; else po ^= d[i];
    end
    return en & (pe | po);
  endfunction

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] d, input logic en, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; chk_en = en;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, {out_valid, out_err, out_data}, {1'b1, exp_err(d, en), d});
  endtask

  initial begin
    logic [W-1:0] base, a, b;
    repeat (3) @(negedge clk);
    chk("R1", {in_ready, out_valid, out_err}, 74'd4);
    rst_n = 1'b1;
    // R2 / R6: clean entries, enable on and off
    for (int k = 0; k < 20; k++) begin
      base = good({$urandom, $urandom, $urandom});
      send(base, 1'b1, "R2");
      send(base, 1'b0, "R6");
    end
    // R3 / R4 / R7: every single flip
    base = good({$urandom, $urandom, $urandom});
    for (int i = 0; i < W; i++) begin
      a = base; a[i] = ~a[i];
      send(a, 1'b1, (i % 2 == 0) ? "R3_R7" : "R4_R7");
      send(a, 1'b0, "R6");
    end
    // R5: every pair of flips
    for (int i = 0; i < W; i++)
      for (int j = i + 1; j < W; j++) begin
        a = base; a[i] = ~a[i]; a[j] = ~a[j];
        send(a, 1'b1, "R5");
      end
    @(negedge clk);
    chk("R9", {73'd0, out_err}, {73'd0, 1'b0});
    // R8 / R10: stall with a late enable change
    a = base; a[5] = ~a[5];
    b = good({$urandom, $urandom, $urandom});
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = a; chk_en = 1'b1;
    @(negedge clk);
    in_data = b; chk_en = 1'b0;
    chk("R8", {73'd0, in_ready}, 74'd0);
    @(negedge clk);
    chk("R10", {out_valid, out_err, out_data}, {1'b1, 1'b1, a});
    chk("R8", {73'd0, in_ready}, 74'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", {out_valid, out_err, out_data}, {1'b1, 1'b0, b});
    @(negedge clk);
    chk("R9", {out_valid, out_err}, 2'b00);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule